// File: doc/BRIEF.md
# Redriver Configuration Write Sequencer

This block turns port events into short scripts of register writes to a single high-speed redriver. Each event has a fixed script. The events are power-up, cable removal, cable insertion in either orientation, and entry into a DisplayPort lane assignment in either orientation. The assignment is either four lanes of DisplayPort or two lanes of DisplayPort plus USB. The scripts set the lane-routing control register, the output gain register and the upstream and downstream equalisation registers. Orientation changes only one bit of the routing value.

The block drives a byte-level I2C controller. It presents one byte at a time, flagged as the first byte of a transaction (the controller issues a start condition) or the last byte (the controller issues a stop condition). It holds the byte until the controller pulses `i2c_done` with the acknowledge result. A two-byte write is one transaction, and the target increments its register pointer by itself.

Events that arrive while a script is running wait in a small in-order queue. A removal event throws away whatever is still waiting. A missing acknowledge aborts the running script. A full queue drops the new event. Each of these two faults sets its own sticky flag.

Top module: `redrv_cfg_seq`

## Requirements
- R1: Every transaction starts with the address byte 0x24 (target 0x12, write), which is the only byte flagged start. It is followed by the register pointer and one or two data bytes, and only the last data byte is flagged stop.
- R2: Event code 0 (power-up) and event code 1 (removal) each write 0x10 to register 0x0A as a single transaction.
- R3: Event code 2 (insertion, normal) writes, in this order: 0x11 to register 0x0A, then 0x58 to register 0x0C, then 0x66 0x66 from register 0x10, then 0x33 0x33 from register 0x20.
- R4: Event code 3 (insertion, flipped) runs the R3 script, except that register 0x0A receives 0x15 (bit 2 set).
- R5: Event codes 4 and 5 (four-lane DisplayPort, normal and flipped) write 0x1A and 0x1E respectively to register 0x0A, then 0x55 0x55 from register 0x10. They make no write to register 0x20, whose previous value therefore stays.
- R6: Event codes 6 and 7 (two lanes plus USB, normal and flipped) write 0x1B and 0x1F respectively to register 0x0A, then the upstream pair (default 0x56 0x56) from register 0x10, then the downstream pair (default 0x33 0x33) from register 0x20.
- R7: A request holds its byte and flags unchanged until `i2c_done`, and the next byte is presented only after that pulse.
- R8: Events are executed strictly in arrival order. `busy` is high from the cycle after an event is accepted until its script and all queued scripts have finished, and it is low after reset.
- R9: A removal event empties every queued event that has not started and is then queued itself. A script already running completes.
- R10: A missing acknowledge ends the running script with no further byte, returns the block to idle and sets `err_nack` until reset.
- R11: An event other than removal that arrives while the queue (depth 4) is full is dropped and sets `err_ovf` until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | One-cycle strobe: an event is presented |
| evt_code | input | 3 | Event code 0 to 7 (see R2 to R6) |
| i2c_req | output | 1 | Byte request to the I2C controller |
| i2c_start | output | 1 | Byte opens a transaction (start condition) |
| i2c_stop | output | 1 | Byte closes a transaction (stop condition) |
| i2c_byte | output | 8 | Byte to transmit |
| i2c_done | input | 1 | One-cycle pulse: current byte finished |
| i2c_ack | input | 1 | Acknowledge for the finished byte, valid with i2c_done |
| busy | output | 1 | A script is running or events are queued |
| err_nack | output | 1 | Sticky: a byte was not acknowledged |
| err_ovf | output | 1 | Sticky: an event was dropped on a full queue |

## Verification
All eight event codes are sent one at a time to an idle block. Comparing byte streams tells the normal and flipped variants apart, and tells the four-lane script apart from the two-lane one. Register 0x20 is preset to a marker before the four-lane event, which shows the omitted write. Back-to-back bursts of mixed events check ordering, a burst ending in removal checks the purge, and a burst one event larger than the queue checks the drop. A negative acknowledge in the middle of an insertion script checks the abort by counting the bytes that never appear.

// File: rtl/redrv_cfg_pkg.sv
package redrv_cfg_pkg;

  typedef enum logic [2:0] {
    EV_POR    = 3'd0,
    EV_DETACH = 3'd1,
    EV_ATT_N  = 3'd2,
    EV_ATT_F  = 3'd3,
    EV_DP4_N  = 3'd4,
    EV_DP4_F  = 3'd5,
    EV_DP2_N  = 3'd6,
    EV_DP2_F  = 3'd7
  } evt_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PREP = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_e;

  typedef struct packed {
    logic       start;
    logic       stop;
    logic       last_byte;
    logic       last_tx;
    logic [7:0] data;
  } step_t;

  localparam logic [7:0] REG_CTL   = 8'h0A;
  localparam logic [7:0] REG_GAIN  = 8'h0C;
  localparam logic [7:0] REG_UEQ   = 8'h10;
  localparam logic [7:0] REG_DEQ   = 8'h20;
  localparam logic [7:0] FLIP_MASK = 8'h04;

endpackage

// File: rtl/redrv_cfg_evtq.sv
module redrv_cfg_evtq #(
  parameter int DEPTH = 4,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         flush,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             we;
  logic [PTR_W-1:0] wr_addr;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_MAX);
  assign we      = push && (flush || !full);
  assign wr_addr = flush ? '0 : wr_ptr;
  assign dout    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= push ? ptr_inc('0) : '0;
      cnt    <= push ? CNT_W'(1) : '0;
    end else begin
      if (we) wr_ptr <= ptr_inc(wr_ptr);
      if (pop && !empty) rd_ptr <= ptr_inc(rd_ptr);
      case ({we, pop && !empty})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/redrv_cfg_script.sv
module redrv_cfg_script
  import redrv_cfg_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h12,
  parameter logic [7:0] ATT_GAIN = 8'h58,
  parameter logic [7:0] ATT_UEQ  = 8'h66,
  parameter logic [7:0] ATT_DEQ  = 8'h33,
  parameter logic [7:0] DP4_UEQ  = 8'h55,
  parameter logic [7:0] DP2_UEQ  = 8'h56,
  parameter logic [7:0] DP2_DEQ  = 8'h33
) (
  input  evt_e       code,
  input  logic [1:0] tx_idx,
  input  logic [1:0] byte_idx,
  output step_t      step
);
  logic [1:0] kind;
  logic [7:0] ctl_val;
  logic [7:0] reg_ptr, d0, d1;
  logic       two;
  logic [1:0] ntx_m1;

  assign kind = code[2:1];

  always_comb begin
    case (kind)
      2'd0:    ctl_val = 8'h10;
      2'd1:    ctl_val = 8'h11;
      2'd2:    ctl_val = 8'h1A;
      default: ctl_val = 8'h1B;
    endcase
    if (kind != 2'd0 && code[0]) ctl_val = ctl_val | FLIP_MASK;
  end

  always_comb begin
    reg_ptr = REG_CTL;
    d0      = ctl_val;
    d1      = 8'h00;
    two     = 1'b0;
    case (kind)
      2'd1:    ntx_m1 = 2'd3;
      2'd2:    ntx_m1 = 2'd1;
      2'd3:    ntx_m1 = 2'd2;
      default: ntx_m1 = 2'd0;
    endcase
    if (tx_idx != 2'd0) begin
      case (kind)
        2'd1: begin
          case (tx_idx)
            2'd1:    begin reg_ptr = REG_GAIN; d0 = ATT_GAIN; end
            2'd2:    begin reg_ptr = REG_UEQ; d0 = ATT_UEQ; d1 = ATT_UEQ; two = 1'b1; end
            default: begin reg_ptr = REG_DEQ; d0 = ATT_DEQ; d1 = ATT_DEQ; two = 1'b1; end
          endcase
        end
        2'd2: begin
          reg_ptr = REG_UEQ; d0 = DP4_UEQ; d1 = DP4_UEQ; two = 1'b1;
        end
        2'd3: begin
          if (tx_idx == 2'd1) begin
            reg_ptr = REG_UEQ; d0 = DP2_UEQ; d1 = DP2_UEQ;
          end else begin
            reg_ptr = REG_DEQ; d0 = DP2_DEQ; d1 = DP2_DEQ;
          end
          two = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (byte_idx)
      2'd0:    step.data = {TGT_ADDR, 1'b0};
      2'd1:    step.data = reg_ptr;
      2'd2:    step.data = d0;
      default: step.data = d1;
    endcase
    step.start     = (byte_idx == 2'd0);
    step.last_byte = two ? (byte_idx == 2'd3) : (byte_idx == 2'd2);
    step.stop      = step.last_byte;
    step.last_tx   = (tx_idx == ntx_m1);
  end
endmodule

// File: rtl/redrv_cfg_engine.sv
module redrv_cfg_engine
  import redrv_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       q_empty,
  input  logic [2:0] q_head,
  output logic       q_pop,
  output evt_e       cur_code,
  output logic [1:0] tx_idx,
  output logic [1:0] byte_idx,
  input  step_t      step,
  output logic       i2c_req,
  output logic       i2c_start,
  output logic       i2c_stop,
  output logic [7:0] i2c_byte,
  input  logic       i2c_done,
  input  logic       i2c_ack,
  output logic       err_nack,
  output logic       running
);
  sq_state_e state;
  logic      last_b, last_t;

  assign q_pop   = (state == SQ_IDLE) && !q_empty;
  assign running = (state != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      cur_code  <= EV_POR;
      tx_idx    <= '0;
      byte_idx  <= '0;
      i2c_req   <= 1'b0;
      i2c_start <= 1'b0;
      i2c_stop  <= 1'b0;
      i2c_byte  <= '0;
      last_b    <= 1'b0;
      last_t    <= 1'b0;
      err_nack  <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (!q_empty) begin
            cur_code <= evt_e'(q_head);
            tx_idx   <= '0;
            byte_idx <= '0;
            state    <= SQ_PREP;
          end
        end
        SQ_PREP: begin
          i2c_req   <= 1'b1;
          i2c_start <= step.start;
          i2c_stop  <= step.stop;
          i2c_byte  <= step.data;
          last_b    <= step.last_byte;
          last_t    <= step.last_tx;
          state     <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (i2c_done) begin
            i2c_req <= 1'b0;
            if (!i2c_ack) begin
              err_nack <= 1'b1;
              state    <= SQ_IDLE;
            end else if (last_b) begin
              if (last_t) begin
                state <= SQ_IDLE;
              end else begin
                tx_idx   <= tx_idx + 1'b1;
                byte_idx <= '0;
                state    <= SQ_PREP;
              end
            end else begin
              byte_idx <= byte_idx + 1'b1;
              state    <= SQ_PREP;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/redrv_cfg_seq.sv
module redrv_cfg_seq
  import redrv_cfg_pkg::*;
#(
  parameter int         QDEPTH   = 4,
  parameter logic [6:0] TGT_ADDR = 7'h12,
  parameter logic [7:0] DP2_UEQ  = 8'h56,
  parameter logic [7:0] DP2_DEQ  = 8'h33
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       evt_valid,
  input  logic [2:0] evt_code,
  output logic       i2c_req,
  output logic       i2c_start,
  output logic       i2c_stop,
  output logic [7:0] i2c_byte,
  input  logic       i2c_done,
  input  logic       i2c_ack,
  output logic       busy,
  output logic       err_nack,
  output logic       err_ovf
);
  localparam int EVW = $bits(evt_e);

  logic           q_empty, q_full, q_pop, q_flush, running;
  logic [EVW-1:0] q_head;
  evt_e           cur_code;
  logic [1:0]     tx_idx, byte_idx;
  step_t          step;

  assign q_flush = evt_valid && (evt_code == EV_DETACH);
  assign busy    = running || !q_empty;

  redrv_cfg_evtq #(.DEPTH(QDEPTH), .W(EVW)) u_q (
    .clk(clk), .rst(rst), .push(evt_valid), .din(evt_code), .flush(q_flush),
    .pop(q_pop), .dout(q_head), .empty(q_empty), .full(q_full)
  );

  redrv_cfg_script #(
    .TGT_ADDR(TGT_ADDR), .DP2_UEQ(DP2_UEQ), .DP2_DEQ(DP2_DEQ)
  ) u_rom (
    .code(cur_code), .tx_idx(tx_idx), .byte_idx(byte_idx), .step(step)
  );

  redrv_cfg_engine u_eng (
    .clk(clk), .rst(rst), .q_empty(q_empty), .q_head(q_head), .q_pop(q_pop),
    .cur_code(cur_code), .tx_idx(tx_idx), .byte_idx(byte_idx), .step(step),
    .i2c_req(i2c_req), .i2c_start(i2c_start), .i2c_stop(i2c_stop),
    .i2c_byte(i2c_byte), .i2c_done(i2c_done), .i2c_ack(i2c_ack),
    .err_nack(err_nack), .running(running)
  );

  always_ff @(posedge clk) begin
    if (rst) err_ovf <= 1'b0;
    else if (evt_valid && q_full && !q_flush) err_ovf <= 1'b1;
  end
endmodule

// File: rtl/redrv_cfg_seq_chk.sv
module redrv_cfg_seq_chk #(
  parameter logic [6:0] TGT_ADDR = 7'h12
) (
  input logic       clk,
  input logic       rst,
  input logic       i2c_req,
  input logic       i2c_start,
  input logic       i2c_stop,
  input logic [7:0] i2c_byte,
  input logic       i2c_done,
  input logic       i2c_ack,
  input logic       busy,
  input logic       err_nack,
  input logic       err_ovf
);
  AST_ADDR_FIRST: assert property (@(posedge clk) disable iff (rst)
    (i2c_req && i2c_start) |-> (i2c_byte == {TGT_ADDR, 1'b0})); // R1
  AST_NO_START_STOP: assert property (@(posedge clk) disable iff (rst)
    i2c_req |-> !(i2c_start && i2c_stop)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (i2c_req && !i2c_done) |=> (i2c_req && $stable(i2c_byte) && $stable(i2c_start) && $stable(i2c_stop))); // R7
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (rst)
    i2c_req |-> busy); // R8
  AST_NACK_DROP: assert property (@(posedge clk) disable iff (rst)
    (i2c_req && i2c_done && !i2c_ack) |=> (!i2c_req && err_nack)); // R10
  AST_NACK_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_nack |=> err_nack); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_ovf |=> err_ovf); // R11
endmodule

bind redrv_cfg_seq redrv_cfg_seq_chk #(.TGT_ADDR(TGT_ADDR)) u_chk (
  .clk(clk), .rst(rst), .i2c_req(i2c_req), .i2c_start(i2c_start),
  .i2c_stop(i2c_stop), .i2c_byte(i2c_byte), .i2c_done(i2c_done),
  .i2c_ack(i2c_ack), .busy(busy), .err_nack(err_nack), .err_ovf(err_ovf)
);

// File: tb/redrv_cfg_seq_tb_top.sv
module redrv_cfg_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       evt_valid = 1'b0;
  logic [2:0] evt_code = 3'd0;
  logic       i2c_req, i2c_start, i2c_stop;
  logic [7:0] i2c_byte;
  logic       i2c_done = 1'b0;
  logic       i2c_ack = 1'b1;
  logic       busy, err_nack, err_ovf;

  int checks = 0;
  int fails  = 0;

  logic [9:0] expq[$];
  logic [7:0] tgt [256];
  int         nack_at = -1;
  int         byte_no = 0;
  bit         pend = 1'b0;
  int         cnt = 0;
  logic [9:0] cap;
  int         ph = 0;
  logic [7:0] ptr = 8'h00;

  always #5 clk = ~clk;

  redrv_cfg_seq dut_i (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_code(evt_code),
    .i2c_req(i2c_req), .i2c_start(i2c_start), .i2c_stop(i2c_stop),
    .i2c_byte(i2c_byte), .i2c_done(i2c_done), .i2c_ack(i2c_ack),
    .busy(busy), .err_nack(err_nack), .err_ovf(err_ovf)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void add_tx(input logic [7:0] r, input int n, input logic [7:0] d0, input logic [7:0] d1);
    expq.push_back({2'b10, 8'h24});
    expq.push_back({2'b00, r});
    if (n == 1) expq.push_back({2'b01, d0});
    else begin
      expq.push_back({2'b00, d0});
      expq.push_back({2'b01, d1});
    end
  endfunction

  function automatic void add_script(input int c);
    logic [7:0] f;
    f = (c >= 2 && (c % 2) == 1) ? 8'h04 : 8'h00;
    case (c / 2)
      0: add_tx(8'h0A, 1, 8'h10, 8'h00);
      1: begin
        add_tx(8'h0A, 1, 8'h11 | f, 8'h00);
        add_tx(8'h0C, 1, 8'h58, 8'h00);
        add_tx(8'h10, 2, 8'h66, 8'h66);
        add_tx(8'h20, 2, 8'h33, 8'h33);
      end
      2: begin
        add_tx(8'h0A, 1, 8'h1A | f, 8'h00);
        add_tx(8'h10, 2, 8'h55, 8'h55);
      end
      default: begin
        add_tx(8'h0A, 1, 8'h1B | f, 8'h00);
        add_tx(8'h10, 2, 8'h56, 8'h56);
        add_tx(8'h20, 2, 8'h33, 8'h33);
      end
    endcase
  endfunction

  // behavioural I2C controller plus target
  initial begin
    for (int i = 0; i < 256; i++) tgt[i] = 8'h00;
    forever begin
      @(negedge clk);
      i2c_done = 1'b0;
      if (pend) begin
        chk(i2c_req && {i2c_start, i2c_stop, i2c_byte} == cap, "R7 request held",
            {i2c_req, i2c_start, i2c_stop, i2c_byte}, {1'b1, cap});
        if (cnt > 0) cnt--;
        else begin
          logic ack;
          ack = (byte_no != nack_at);
          i2c_done = 1'b1;
          i2c_ack  = ack;
          if (expq.size() == 0) chk(1'b0, "R1 unexpected byte", cap, 0);
          else begin
            logic [9:0] e;
            e = expq.pop_front();
            chk(cap == e, "R1-stream byte R2 R3 R4 R5 R6", cap, e);
          end
          if (ack) begin
            if (cap[9]) ph = 0;
            if (ph == 1) ptr = cap[7:0];
            else if (ph >= 2) begin
              tgt[ptr] = cap[7:0];
              ptr = ptr + 8'd1;
            end
            ph++;
          end
          byte_no++;
          pend = 1'b0;
        end
      end else if (i2c_req) begin
        pend = 1'b1;
        cnt  = 1;
        cap  = {i2c_start, i2c_stop, i2c_byte};
      end
    end
  end

  task automatic send(input int c);
    @(negedge clk);
    evt_valid = 1'b1;
    evt_code  = 3'(c);
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 3) begin
      @(negedge clk);
      if (!busy && !pend && !i2c_req) quiet++;
      else quiet = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy, "R8 reset busy", busy, 0);
    chk(!i2c_req, "R7 reset req", i2c_req, 0);
    chk(!err_nack && !err_ovf, "R10 R11 reset errors", {err_nack, err_ovf}, 0);

    // single-event sweep over all codes
    for (int c = 0; c < 8; c++) begin
      logic [7:0] f;
      f = (c >= 2 && (c % 2) == 1) ? 8'h04 : 8'h00;
      if (c == 4 || c == 5) tgt[8'h20] = 8'hA5;
      add_script(c);
      send(c);
      wait_idle();
      chk(expq.size() == 0, "R2 R3 R4 R5 R6 script complete", expq.size(), 0);
      case (c / 2)
        0: chk(tgt[8'h0A] == 8'h10, "R2 ctl", tgt[8'h0A], 8'h10);
        1: begin
          chk(tgt[8'h0A] == (8'h11 | f), "R3 R4 ctl", tgt[8'h0A], 8'h11 | f);
          chk(tgt[8'h0C] == 8'h58, "R3 gain", tgt[8'h0C], 8'h58);
          chk(tgt[8'h11] == 8'h66, "R3 ueq auto-inc", tgt[8'h11], 8'h66);
          chk(tgt[8'h21] == 8'h33, "R3 deq auto-inc", tgt[8'h21], 8'h33);
        end
        2: begin
          chk(tgt[8'h0A] == (8'h1A | f), "R5 ctl", tgt[8'h0A], 8'h1A | f);
          chk(tgt[8'h11] == 8'h55, "R5 ueq", tgt[8'h11], 8'h55);
          chk(tgt[8'h20] == 8'hA5, "R5 deq untouched", tgt[8'h20], 8'hA5);
        end
        default: begin
          chk(tgt[8'h0A] == (8'h1B | f), "R6 ctl", tgt[8'h0A], 8'h1B | f);
          chk(tgt[8'h10] == 8'h56 && tgt[8'h11] == 8'h56, "R6 ueq", tgt[8'h11], 8'h56);
          chk(tgt[8'h20] == 8'h33 && tgt[8'h21] == 8'h33, "R6 deq", tgt[8'h21], 8'h33);
        end
      endcase
    end

    // back-to-back burst, arrival order
    add_script(3); add_script(7); add_script(4);
    send(3); send(7); send(4);
    chk(busy, "R8 busy during burst", busy, 1);
    wait_idle();
    chk(expq.size() == 0, "R8 burst order", expq.size(), 0);
    chk(tgt[8'h0A] == 8'h1A, "R8 last event wins", tgt[8'h0A], 8'h1A);

    // removal purges queued events, running script completes
    add_script(2); add_script(1);
    send(2);
    repeat (3) @(negedge clk);
    send(4); send(6); send(1);
    wait_idle();
    chk(expq.size() == 0, "R9 purge stream", expq.size(), 0);
    chk(tgt[8'h0A] == 8'h10, "R9 final ctl", tgt[8'h0A], 8'h10);
    chk(tgt[8'h10] == 8'h66, "R9 purged dp not run", tgt[8'h10], 8'h66);

    // negative acknowledge on register pointer of second transaction
    nack_at = byte_no + 4;
    add_script(2);
    send(2);
    wait_idle();
    chk(expq.size() == 9, "R10 abort leaves rest unsent", expq.size(), 9);
    chk(err_nack, "R10 err set", err_nack, 1);
    chk(!busy, "R10 idle", busy, 0);
    expq.delete();
    nack_at = -1;
    add_script(0);
    send(0);
    wait_idle();
    chk(expq.size() == 0 && tgt[8'h0A] == 8'h10, "R10 recovers", expq.size(), 0);
    chk(err_nack, "R10 sticky", err_nack, 1);

    // queue overflow
    chk(!err_ovf, "R11 clear before", err_ovf, 0);
    add_script(3); add_script(4); add_script(5); add_script(6); add_script(7);
    send(3);
    repeat (3) @(negedge clk);
    send(4); send(5); send(6); send(7); send(2);
    chk(err_ovf, "R11 overflow flag", err_ovf, 1);
    wait_idle();
    chk(expq.size() == 0, "R11 dropped event absent", expq.size(), 0);
    chk(tgt[8'h0A] == 8'h1F, "R11 last kept event", tgt[8'h0A], 8'h1F);
    chk(err_ovf, "R11 sticky", err_ovf, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule